// File: doc/BRIEF.md
# System-Management Memory Access Controller

This block decides where each memory request goes when system-management memory is in play. It holds two one-byte control registers and one 16-bit extended-size register, all written and read through a small configuration port. For every request it looks at the address and at whether the requester runs in system-management mode (SMM). It then returns a route code: DRAM, PCI/graphics space, a black hole that returns all ones and drops writes, or "not claimed" for addresses it does not own.

It handles three regions. The first is the legacy window at 0xA0000..0xBFFFF. The second is a 128 KB high alias at 0xFEDA0000..0xFEDBFFFF, which shows the legacy DRAM. The third is a carved-out segment that ends at the top of memory below 4 GB; its size comes from a size field or from a configured megabyte count. SMM requesters and normal requesters see different views. A one-way seal bit locks the configuration until reset.

The seal is kept in a two-state machine. The states are `LK_UNSEALED`, the reset state, in which the full write masks apply, and `LK_SEALED`, in which reduced masks apply. There is one transition, `seal_write`, from `LK_UNSEALED` to `LK_SEALED`, taken on a write to the control register with the seal bit set. `LK_SEALED` only returns to `LK_UNSEALED` through reset.

Top module: `smtseg_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the extended register (address 1) read 0. The size register (address 2) reads 0xFFFF when `ext_tseg_mb` is nonzero and 0 otherwise. Address 3 always reads 0.
- R2: Route codes are 0 = not claimed, 1 = DRAM, 2 = PCI space, 3 = black hole. While unsealed, control-register bits 6 (open), 5 (close), 4 (seal) and 3 (global enable) are writable, and its other bits read 0. Extended-register bits 7 (high enable), 2:1 (segment size) and 0 (segment enable) are writable, and its other bits read 0.
- R3: A control write with bit 4 set forces bit 6 to 0, even if bit 6 is set in the same write, and seals the block. Once sealed, only bit 5 of the control register can change and the extended register cannot change, until reset.
- R4: For a non-SMM request to 0xA0000..0xBFFFF: with open=1 and high enable=1 the route is PCI; with open=1 and high enable=0 it is DRAM; with open=0 it is PCI.
- R5: For a non-SMM request to 0xFEDA0000..0xFEDBFFFF, the route is DRAM when open=1 and high enable=1, and not claimed otherwise.
- R6: For an SMM request with global enable=1, the legacy window routes to DRAM when high enable=0, and the high alias routes to DRAM when high enable=1. In every other case, including global enable=0, an SMM request gets the non-SMM route.
- R7: When bit 0 of the extended register is set, the segment size is 1 MB for code 00, 2 MB for code 01, 8 MB for code 10, and `ext_tseg_mb` MB for code 11. When bit 0 is clear the size is zero and nothing is carved.
- R8: The segment covers [`low_mem_top` - size, `low_mem_top`). Non-SMM requests in it route to black hole and SMM requests route to DRAM. Addresses outside all three regions are not claimed.
- R9: A write of 0xFFFF to the size register stores `ext_tseg_mb` when that input is nonzero. Any other written value is stored as written.
- R10: The route is combinational from the request and the registered state. A register write changes the route from the clock edge that captures it onward, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for read and write (0 control, 1 extended, 2 size) |
| cfg_wr_data | input | 16 | Write data; the byte registers use bits 7:0 |
| cfg_rd_data | output | 16 | Combinational read data for `cfg_addr` |
| low_mem_top | input | 32 | Size of memory below 4 GB, in bytes |
| ext_tseg_mb | input | 12 | Configured extended segment size in MB |
| req_addr | input | 32 | Request address |
| req_smm | input | 1 | Requester is in system-management mode |
| route | output | 2 | Route code for the request |

## Verification
The route is a pure function of the request and the registers, so the bench checks it shortly after driving an address, with no clock edge in between. A register write is captured by the rising edge inside a write strobe. Its effect on both `cfg_rd_data` and `route` is due one cycle after the strobe is raised. The bench therefore raises each strobe at a falling edge and checks only after the next falling edge. The timing scenario also samples the route just before the capturing edge to confirm that the old route is still in effect.

// File: rtl/smtseg_pkg.sv
package smtseg_pkg;
    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_DRAM = 2'd1,
        RT_PCI  = 2'd2,
        RT_HOLE = 2'd3
    } route_e;

    typedef enum logic {
        LK_UNSEALED = 1'b0,
        LK_SEALED   = 1'b1
    } lock_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_EXT   = 2'd1;
    localparam logic [1:0] A_XSIZE = 2'd2;

    localparam int B_OPEN  = 6;
    localparam int B_CLOSE = 5;
    localparam int B_SEAL  = 4;
    localparam int B_GEN   = 3;
    localparam int B_HEN   = 7;
    localparam int B_TEN   = 0;

    localparam logic [7:0] M_CTRL_FULL   = 8'h78;
    localparam logic [7:0] M_CTRL_SEALED = 8'h20;
    localparam logic [7:0] M_EXT_FULL    = 8'h87;
    localparam logic [7:0] M_EXT_SEALED  = 8'h00;

    localparam logic [15:0] XSIZE_QUERY = 16'hFFFF;
    localparam int          MB_SHIFT    = 20;

    localparam logic [31:0] LEG_LO = 32'h000A_0000;
    localparam logic [31:0] LEG_HI = 32'h000B_FFFF;
    localparam logic [31:0] ALI_LO = 32'hFEDA_0000;
    localparam logic [31:0] ALI_HI = 32'hFEDB_FFFF;
endpackage

// File: rtl/smtseg_regs.sv
module smtseg_regs
    import smtseg_pkg::*;
#(
    parameter int EXT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [15:0]      wr_data,
    input  logic [EXT_W-1:0] ext_mb,
    output logic [15:0]      rd_data,
    output logic [7:0]       ctrl_q,
    output logic [7:0]       ext_q
);
    lock_e       lk_q, lk_d;
    logic [7:0]  ctrl_mask, ext_mask, ctrl_nxt;
    logic [15:0] xsize_q;
    logic [15:0] ext_mb16;
    logic        seal_write;

    assign ext_mb16   = 16'(ext_mb);
    assign seal_write = wr_en && (addr == A_CTRL) && wr_data[B_SEAL];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= LK_UNSEALED;
        else        lk_q <= lk_d;
    end

    // next state
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_UNSEALED: if (seal_write) lk_d = LK_SEALED;
            LK_SEALED:   lk_d = LK_SEALED;
        endcase
    end

    // per-state write masks
    always_comb begin
        unique case (lk_q)
            LK_UNSEALED: begin
                ctrl_mask = M_CTRL_FULL;
                ext_mask  = M_EXT_FULL;
            end
            LK_SEALED: begin
                ctrl_mask = M_CTRL_SEALED;
                ext_mask  = M_EXT_SEALED;
            end
        endcase
    end

    always_comb begin
        ctrl_nxt = (ctrl_q & ~ctrl_mask) | (wr_data[7:0] & ctrl_mask);
        if (ctrl_nxt[B_SEAL]) ctrl_nxt[B_OPEN] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 8'h00;
            ext_q   <= 8'h00;
            xsize_q <= (ext_mb16 != 16'd0) ? XSIZE_QUERY : 16'd0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL:  ctrl_q <= ctrl_nxt;
                A_EXT:   ext_q  <= (ext_q & ~ext_mask) | (wr_data[7:0] & ext_mask);
                A_XSIZE: xsize_q <= (ext_mb16 != 16'd0 && wr_data == XSIZE_QUERY)
                                    ? ext_mb16 : wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rd_data = {8'h00, ctrl_q};
            A_EXT:   rd_data = {8'h00, ext_q};
            A_XSIZE: rd_data = xsize_q;
            default: rd_data = 16'h0000;
        endcase
    end

    assert_seal_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q == LK_SEALED |=> lk_q == LK_SEALED);

    assert_ext_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SEALED && wr_en && addr == A_EXT) |=> $stable(ext_q));

    assert_open_low_when_sealed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seal_write |=> !ctrl_q[B_OPEN]);

    assert_query_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_XSIZE && wr_data == XSIZE_QUERY && ext_mb16 != 16'd0)
        |=> xsize_q == $past(ext_mb16));
endmodule

// File: rtl/smtseg_size.sv
module smtseg_size
    import smtseg_pkg::*;
#(
    parameter int EXT_W = 12,
    parameter int AW    = 32
) (
    input  logic             seg_en,
    input  logic [1:0]       seg_code,
    input  logic [EXT_W-1:0] ext_mb,
    input  logic [AW-1:0]    top,
    output logic             seg_on,
    output logic [AW-1:0]    seg_base
);
    localparam int SW = AW + 1;

    logic [EXT_W-1:0] size_mb;
    logic [SW-1:0]    size_b;
    logic [SW-1:0]    top_w;

    always_comb begin
        size_mb = '0;
        if (seg_en) begin
            unique case (seg_code)
                2'b00: size_mb = EXT_W'(1);
                2'b01: size_mb = EXT_W'(2);
                2'b10: size_mb = EXT_W'(8);
                2'b11: size_mb = ext_mb;
            endcase
        end
    end

    assign size_b   = SW'(size_mb) << MB_SHIFT;
    assign top_w    = SW'(top);
    assign seg_on   = (size_b != '0);
    assign seg_base = (size_b > top_w) ? '0 : AW'(top_w - size_b);
endmodule

// File: rtl/smtseg_route.sv
module smtseg_route
    import smtseg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          smm,
    input  logic          open_b,
    input  logic          gen_b,
    input  logic          hen_b,
    input  logic          seg_on,
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] top,
    output route_e        route
);
    logic   in_leg, in_ali, in_seg;
    route_e normal;

    assign in_leg = (addr >= AW'(LEG_LO)) && (addr <= AW'(LEG_HI));
    assign in_ali = (addr >= AW'(ALI_LO)) && (addr <= AW'(ALI_HI));
    assign in_seg = seg_on && (addr >= seg_base) && (addr < top);

    always_comb begin
        if (in_leg)      normal = (open_b && !hen_b) ? RT_DRAM : RT_PCI;
        else if (in_ali) normal = (open_b && hen_b) ? RT_DRAM : RT_NONE;
        else if (in_seg) normal = RT_HOLE;
        else             normal = RT_NONE;
    end

    always_comb begin
        route = normal;
        if (smm) begin
            if (in_leg)      route = (gen_b && !hen_b) ? RT_DRAM : normal;
            else if (in_ali) route = (gen_b && hen_b) ? RT_DRAM : normal;
            else if (in_seg) route = RT_DRAM;
        end
    end
endmodule

// File: rtl/smtseg_ctrl.sv
module smtseg_ctrl
    import smtseg_pkg::*;
#(
    parameter int EXT_W = 12,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_addr,
    input  logic [15:0]      cfg_wr_data,
    output logic [15:0]      cfg_rd_data,
    input  logic [AW-1:0]    low_mem_top,
    input  logic [EXT_W-1:0] ext_tseg_mb,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_smm,
    output logic [1:0]       route
);
    logic [7:0]    ctrl_q, ext_q;
    logic          seg_on;
    logic [AW-1:0] seg_base;
    route_e        rt;

    smtseg_regs #(.EXT_W(EXT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wr_data(cfg_wr_data), .ext_mb(ext_tseg_mb), .rd_data(cfg_rd_data),
        .ctrl_q(ctrl_q), .ext_q(ext_q)
    );

    smtseg_size #(.EXT_W(EXT_W), .AW(AW)) u_size (
        .seg_en(ext_q[B_TEN]), .seg_code(ext_q[2:1]), .ext_mb(ext_tseg_mb),
        .top(low_mem_top), .seg_on(seg_on), .seg_base(seg_base)
    );

    smtseg_route #(.AW(AW)) u_route (
        .addr(req_addr), .smm(req_smm), .open_b(ctrl_q[B_OPEN]),
        .gen_b(ctrl_q[B_GEN]), .hen_b(ext_q[B_HEN]), .seg_on(seg_on),
        .seg_base(seg_base), .top(low_mem_top), .route(rt)
    );

    assign route = rt;

    assert_hole_only_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        route == RT_HOLE |-> !req_smm);

    assert_alias_needs_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_smm && req_addr >= AW'(ALI_LO) && req_addr <= AW'(ALI_HI) && route == RT_DRAM)
        |-> (ctrl_q[B_OPEN] && ext_q[B_HEN]));

    assert_smm_legacy_dram_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_smm && ctrl_q[B_GEN] && !ext_q[B_HEN] &&
         req_addr >= AW'(LEG_LO) && req_addr <= AW'(LEG_HI)) |-> route == RT_DRAM);
endmodule

// File: tb/test_smtseg_ctrl.sv
module test_smtseg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wr_data = 16'd0;
    logic [15:0] cfg_rd_data;
    logic [31:0] low_mem_top = 32'h8000_0000;
    logic [11:0] ext_tseg_mb = 12'd16;
    logic [31:0] req_addr = 32'd0;
    logic        req_smm = 1'b0;
    logic [1:0]  route;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [1:0] NONE = 2'd0, DRAM = 2'd1, PCI = 2'd2, HOLE = 2'd3;
    localparam logic [31:0] MB = 32'h0010_0000;

    always #2 clk = ~clk;

    smtseg_ctrl i_smtseg_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .low_mem_top(low_mem_top), .ext_tseg_mb(ext_tseg_mb),
        .req_addr(req_addr), .req_smm(req_smm), .route(route)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        cfg_addr = a;
        #0.5;
        chk(tag, 32'(cfg_rd_data), 32'(exp));
    endtask

    task automatic rt_chk(input string tag, input logic [31:0] a, input logic s,
                          input logic [1:0] exp);
        req_addr = a; req_smm = s;
        #0.5;
        chk(tag, 32'(route), 32'(exp));
    endtask

    task automatic t_reset();
        ext_tseg_mb = 12'd0;
        do_reset();
        rd_chk("R1 size reg reset, no ext", 2'd2, 16'h0000);
        wr(2'd2, 16'hFFFF);
        rd_chk("R9 query stored as written when ext=0", 2'd2, 16'hFFFF);
        ext_tseg_mb = 12'd16;
        do_reset();
        rd_chk("R1 ctrl reset", 2'd0, 16'h0000);
        rd_chk("R1 ext reset", 2'd1, 16'h0000);
        rd_chk("R1 size reg reset query", 2'd2, 16'hFFFF);
        rd_chk("R1 addr3 reads 0", 2'd3, 16'h0000);
        rt_chk("R4 reset legacy PCI", 32'h000A_0000, 1'b0, PCI);
        rt_chk("R5 reset alias hidden", 32'hFEDA_0000, 1'b0, NONE);
        rt_chk("R8 reset top-1 unclaimed", low_mem_top - 1, 1'b0, NONE);
    endtask

    task automatic t_masks();
        do_reset();
        wr(2'd0, 16'hFFEF);
        rd_chk("R2 ctrl mask", 2'd0, 16'h0068);
        wr(2'd1, 16'hFFFF);
        rd_chk("R2 ext mask", 2'd1, 16'h0087);
    endtask

    task automatic t_normal_view();
        do_reset();
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'h0080);
        rt_chk("R4 open+hen legacy PCI", 32'h000B_FFFF, 1'b0, PCI);
        rt_chk("R5 open+hen alias DRAM lo", 32'hFEDA_0000, 1'b0, DRAM);
        rt_chk("R5 open+hen alias DRAM hi", 32'hFEDB_FFFF, 1'b0, DRAM);
        rt_chk("R8 above alias unclaimed", 32'hFEDC_0000, 1'b0, NONE);
        rt_chk("R8 below legacy unclaimed", 32'h0009_FFFF, 1'b0, NONE);
        wr(2'd1, 16'h0000);
        rt_chk("R4 open, hen=0 legacy DRAM", 32'h000A_0000, 1'b0, DRAM);
        rt_chk("R5 open, hen=0 alias hidden", 32'hFEDA_0000, 1'b0, NONE);
        wr(2'd0, 16'h0000);
        rt_chk("R4 closed legacy PCI", 32'h000A_0000, 1'b0, PCI);
    endtask

    task automatic t_smm_view();
        do_reset();
        wr(2'd0, 16'h0008);
        rt_chk("R6 gen, hen=0 legacy DRAM", 32'h000A_1234, 1'b1, DRAM);
        rt_chk("R6 gen, hen=0 alias falls back", 32'hFEDA_0000, 1'b1, NONE);
        wr(2'd1, 16'h0080);
        rt_chk("R6 gen+hen alias DRAM", 32'hFEDB_0000, 1'b1, DRAM);
        rt_chk("R6 gen+hen legacy falls back PCI", 32'h000A_0000, 1'b1, PCI);
        wr(2'd0, 16'h0000);
        rt_chk("R6 no gen alias hidden", 32'hFEDB_0000, 1'b1, NONE);
        rt_chk("R6 no gen legacy PCI", 32'h000A_0000, 1'b1, PCI);
    endtask

    task automatic seg_probe(input string tag, input logic [31:0] size);
        rt_chk({tag, " base normal hole"}, low_mem_top - size, 1'b0, HOLE);
        rt_chk({tag, " base smm dram"}, low_mem_top - size, 1'b1, DRAM);
        rt_chk({tag, " top-1 normal hole"}, low_mem_top - 1, 1'b0, HOLE);
        rt_chk({tag, " below base"}, low_mem_top - size - 1, 1'b0, NONE);
        rt_chk({tag, " at top"}, low_mem_top, 1'b0, NONE);
    endtask

    task automatic t_segment();
        do_reset();
        wr(2'd1, 16'h0001); seg_probe("R7 R8 1MB", MB);
        wr(2'd1, 16'h0003); seg_probe("R7 R8 2MB", 2 * MB);
        wr(2'd1, 16'h0005); seg_probe("R7 R8 8MB", 8 * MB);
        wr(2'd1, 16'h0007); seg_probe("R7 R8 ext 16MB", 16 * MB);
        wr(2'd1, 16'h0006);
        rt_chk("R7 disabled top-1", low_mem_top - 1, 1'b0, NONE);
    endtask

    task automatic t_query();
        do_reset();
        wr(2'd2, 16'h1234);
        rd_chk("R9 plain value stored", 2'd2, 16'h1234);
        wr(2'd2, 16'hFFFF);
        rd_chk("R9 query answered", 2'd2, 16'd16);
    endtask

    task automatic t_seal();
        do_reset();
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0058);
        rd_chk("R3 seal clears open", 2'd0, 16'h0018);
        rt_chk("R3 sealed legacy PCI", 32'h000A_0000, 1'b0, PCI);
        wr(2'd0, 16'h0068);
        rd_chk("R3 sealed ctrl only close", 2'd0, 16'h0038);
        wr(2'd1, 16'h0080);
        rd_chk("R3 sealed ext frozen", 2'd1, 16'h0003);
        wr(2'd0, 16'h0000);
        rd_chk("R3 seal survives clear", 2'd0, 16'h0018);
        do_reset();
        wr(2'd0, 16'h0040);
        rd_chk("R3 reset unseals", 2'd0, 16'h0040);
    endtask

    task automatic t_timing();
        do_reset();
        req_addr = low_mem_top - 1; req_smm = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 2'd1; cfg_wr_data = 16'h0001;
        #1;
        chk("R10 before edge old route", 32'(route), 32'(NONE));
        @(posedge clk);
        #0.5;
        chk("R10 after edge new route", 32'(route), 32'(HOLE));
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_masks();
        t_normal_view();
        t_smm_view();
        t_segment();
        t_query();
        t_seal();
        t_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule